// File: doc/BRIEF.md
# Configuration Memory Error Shadow Controller

This block sits on the path from a protected configuration store to the logic that reads it. The store holds data bits and check bits. An external checking circuit supplies a corrected copy of both and a single error flag. While no error is flagged, the consumer sees the stored word through a short matched delay line. The delay line exists so that a newly raised error flag can switch the output multiplexer before the faulty word reaches the output.

When the error flag rises, the corrected word is captured into a shadow register. The consumer is fed from that register, so the upset never reaches it. For as long as the flag stays high, the block also writes the corrected word back into the store. If the flag stays high for more cycles than a programmable limit, the block raises a scrub request and a halt request. The halt request asks the consuming device to stop for a full serial reload. Both requests stay raised until they are acknowledged, and the consumer stays on the shadow values for that whole time.

Top module: `cfg_shadow_ctrl`

## Requirements
- R1: With no error pending, `{out_data,out_chk}` equals the `{raw_data,raw_chk}` sampled DLY rising edges earlier (DLY = 2 by default).
- R2: On an edge where `err_in` is 1 and was 0 on the previous edge, the outputs take `{fix_data,fix_chk}` from that edge. They keep that value while `err_in` stays 1, even if the corrected word changes. If `err_in` rises again, a new capture is taken.
- R3: After `err_in` falls, the shadow value is still output on the first edge where `err_in` is 0. The output returns to the delayed raw path on the second such edge, provided no scrub request is pending.
- R4: `wr_en` is 1 after any edge that sampled `err_in`=1 and 0 after any edge that sampled `err_in`=0. `{wr_data,wr_chk}` is the `{fix_data,fix_chk}` sampled on that same edge.
- R5: A counter tracks consecutive edges with `err_in`=1. It is cleared on any edge with `err_in`=0 and saturates at its maximum. `scrub_req` is set on the edge where the count becomes greater than `tmo_limit`, so `tmo_limit`=0 fires on the first edge of an error.
- R6: `halt_req` is always equal to `scrub_req`.
- R7: Once set, `scrub_req` stays 1 until an edge with `scrub_ack`=1 and no new firing. When the set and clear conditions meet on the same edge, the set wins. While `scrub_req` is 1, the outputs hold the shadow value.
- R8: A synchronous active-high `rst` clears all outputs, the delay line, the shadow register and the counter to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_data | input | DATA_W | Data bits as read from the store |
| raw_chk | input | CHK_W | Check bits as read from the store |
| fix_data | input | DATA_W | Corrected data bits from the checker |
| fix_chk | input | CHK_W | Corrected check bits from the checker |
| err_in | input | 1 | Error flag from the checker |
| tmo_limit | input | TMO_W | Number of consecutive error cycles allowed before scrubbing |
| scrub_ack | input | 1 | Acknowledge that clears the scrub request |
| out_data | output | DATA_W | Data bits exported to the consumer |
| out_chk | output | CHK_W | Check bits exported to the consumer |
| wr_en | output | 1 | Write enable for the repair path into the store |
| wr_data | output | DATA_W | Data bits written back by the repair path |
| wr_chk | output | CHK_W | Check bits written back by the repair path |
| scrub_req | output | 1 | Scrub trigger |
| halt_req | output | 1 | Request that the consumer halt for a full reload |

## Verification
Two pairs of events can land on the same edge. First, the timeout can fire on the same edge as an acknowledge. The bench provokes this by holding `scrub_ack` high while `err_in` is still high past the limit, and expects the request to stay set. Second, the error can rise again during the one-cycle release window that follows a fall. The bench drops the flag for a single cycle and then raises it, and expects a fresh capture with no glimpse of the raw path. A behavioural model with a queue for the delay line predicts every output on every edge, and the bench compares the design against it.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
  // source selected by the output multiplexer
  typedef enum logic {
    SRC_RAW   = 1'b0,
    SRC_SHADOW = 1'b1
  } src_e;
endpackage

// File: rtl/cfg_shadow_dly.sv
module cfg_shadow_dly #(
  parameter int W   = 22,
  parameter int DLY = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DLY];

  for (genvar i = 0; i < DLY; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[DLY-1];
endmodule

// File: rtl/cfg_shadow_tmo.sv
module cfg_shadow_tmo #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_in,
  input  logic [TMO_W-1:0] limit,
  input  logic             ack,
  output logic             scrub_req,
  output logic             halt_req
);
  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  logic [TMO_W-1:0] cnt, cnt_nxt;
  logic             fire;

  always_comb begin
    if (!err_in)             cnt_nxt = '0;
    else if (cnt == CNT_MAX) cnt_nxt = cnt;
    else                     cnt_nxt = cnt + 1'b1;
    fire = err_in && (cnt_nxt > limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      scrub_req <= 1'b0;
      halt_req  <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      if (fire) begin
        scrub_req <= 1'b1;
        halt_req  <= 1'b1;
      end else if (ack) begin
        scrub_req <= 1'b0;
        halt_req  <= 1'b0;
      end
    end
  end

  // R5: a low error flag clears the run counter
  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !err_in |=> (cnt == '0));
  // R5: no request can appear without an error present
  p_no_fire_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!err_in && !scrub_req) |=> !scrub_req);
  // R6: halt request mirrors the scrub trigger
  p_halt_mirror_r6: assert property (@(posedge clk) disable iff (rst)
    scrub_req == halt_req);
  // R7: a pending request persists without acknowledge
  p_pend_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (scrub_req && !ack) |=> scrub_req);
  // R7: acknowledge with no error clears the request
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (scrub_req && ack && !err_in) |=> !scrub_req);
endmodule

// File: rtl/cfg_shadow_mux.sv
module cfg_shadow_mux
  import cfg_shadow_pkg::*;
#(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         err_in,
  input  logic         scrub_pend,
  input  logic [W-1:0] fix_word,
  input  logic [W-1:0] raw_word,
  output logic [W-1:0] out_word,
  output logic         wr_en,
  output logic [W-1:0] wr_word
);
  logic         err_prev;
  logic [W-1:0] shadow, shadow_nxt;
  logic         rise;
  src_e         src;

  always_comb begin
    rise       = err_in && !err_prev;
    shadow_nxt = rise ? fix_word : shadow;
    src        = (err_in || err_prev || scrub_pend) ? SRC_SHADOW : SRC_RAW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_prev <= 1'b0;
      shadow   <= '0;
      out_word <= '0;
      wr_en    <= 1'b0;
      wr_word  <= '0;
    end else begin
      err_prev <= err_in;
      shadow   <= shadow_nxt;
      out_word <= (src == SRC_SHADOW) ? shadow_nxt : raw_word;
      wr_en    <= err_in;
      wr_word  <= fix_word;
    end
  end

  // R2: the corrected word appears on the edge the error rises
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (err_in && !err_prev) |=> (out_word == $past(fix_word)));
  // R2: the exported word stays fixed while the error persists
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (err_in && err_prev) |=> $stable(out_word));
  // R3: after a full low cycle the raw path returns
  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    (!err_in && !err_prev && !scrub_pend) |=> (out_word == $past(raw_word)));
  // R4: write enable follows the error flag
  p_wr_on_r4: assert property (@(posedge clk) disable iff (rst)
    err_in |=> wr_en);
  p_wr_off_r4: assert property (@(posedge clk) disable iff (rst)
    !err_in |=> !wr_en);
  // R7: output held while a scrub request is pending
  p_pend_out_r7: assert property (@(posedge clk) disable iff (rst)
    (scrub_pend && !err_in && err_prev) |=> $stable(out_word));
endmodule

// File: rtl/cfg_shadow_ctrl.sv
module cfg_shadow_ctrl #(
  parameter int DATA_W = 16,
  parameter int CHK_W  = 6,
  parameter int DLY    = 2,
  parameter int TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] raw_data,
  input  logic [CHK_W-1:0]  raw_chk,
  input  logic [DATA_W-1:0] fix_data,
  input  logic [CHK_W-1:0]  fix_chk,
  input  logic              err_in,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              scrub_ack,
  output logic [DATA_W-1:0] out_data,
  output logic [CHK_W-1:0]  out_chk,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [CHK_W-1:0]  wr_chk,
  output logic              scrub_req,
  output logic              halt_req
);
  localparam int W = DATA_W + CHK_W;

  logic [W-1:0] raw_dly, out_word, wr_word;

  cfg_shadow_dly #(.W(W), .DLY(DLY)) dly_i (
    .clk  (clk),
    .rst  (rst),
    .din  ({raw_data, raw_chk}),
    .dout (raw_dly)
  );

  cfg_shadow_tmo #(.TMO_W(TMO_W)) tmo_i (
    .clk       (clk),
    .rst       (rst),
    .err_in    (err_in),
    .limit     (tmo_limit),
    .ack       (scrub_ack),
    .scrub_req (scrub_req),
    .halt_req  (halt_req)
  );

  cfg_shadow_mux #(.W(W)) mux_i (
    .clk        (clk),
    .rst        (rst),
    .err_in     (err_in),
    .scrub_pend (scrub_req),
    .fix_word   ({fix_data, fix_chk}),
    .raw_word   (raw_dly),
    .out_word   (out_word),
    .wr_en      (wr_en),
    .wr_word    (wr_word)
  );

  assign {out_data, out_chk} = out_word;
  assign {wr_data, wr_chk}   = wr_word;
endmodule

// File: tb/cfg_shadow_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfg_shadow_ctrl_tb_top;
  localparam int DATA_W = 16;
  localparam int CHK_W  = 6;
  localparam int DLY    = 2;
  localparam int TMO_W  = 8;
  localparam int W      = DATA_W + CHK_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DATA_W-1:0] raw_data = '0, fix_data = '0;
  logic [CHK_W-1:0]  raw_chk = '0, fix_chk = '0;
  logic err_in = 1'b0, scrub_ack = 1'b0;
  logic [TMO_W-1:0] tmo_limit = 8'd5;
  logic [DATA_W-1:0] out_data, wr_data;
  logic [CHK_W-1:0]  out_chk, wr_chk;
  logic wr_en, scrub_req, halt_req;

  always #4 clk = ~clk;

  cfg_shadow_ctrl #(.DATA_W(DATA_W), .CHK_W(CHK_W), .DLY(DLY), .TMO_W(TMO_W)) dut_i (
    .clk(clk), .rst(rst), .raw_data(raw_data), .raw_chk(raw_chk),
    .fix_data(fix_data), .fix_chk(fix_chk), .err_in(err_in),
    .tmo_limit(tmo_limit), .scrub_ack(scrub_ack), .out_data(out_data),
    .out_chk(out_chk), .wr_en(wr_en), .wr_data(wr_data), .wr_chk(wr_chk),
    .scrub_req(scrub_req), .halt_req(halt_req)
  );

  int n_tests = 0, n_fail = 0;
  string tag = "R8";

  // behavioural reference state
  logic [W-1:0] m_q[$];
  logic [W-1:0] m_shadow = '0, m_out = '0, m_wr = '0;
  logic m_wr_en = 0, m_scrub = 0, m_prev = 0;
  int m_run = 0;

  always @(posedge clk) begin
    logic hold;
    logic [W-1:0] rawd;
    if (rst) begin
      m_q.delete();
      for (int i = 0; i < DLY; i++) m_q.push_back('0);
      m_shadow = '0; m_out = '0; m_wr = '0;
      m_wr_en = 0; m_scrub = 0; m_prev = 0; m_run = 0;
    end else begin
      rawd = m_q.pop_front();
      m_q.push_back({raw_data, raw_chk});
      if (err_in && !m_prev) m_shadow = {fix_data, fix_chk};
      hold = err_in || m_prev || m_scrub;
      m_out = hold ? m_shadow : rawd;
      m_wr_en = err_in;
      m_wr = {fix_data, fix_chk};
      if (err_in) m_run = (m_run == 255) ? 255 : m_run + 1; else m_run = 0;
      if (err_in && m_run > int'(tmo_limit)) m_scrub = 1;
      else if (scrub_ack) m_scrub = 0;
      m_prev = err_in;
    end
  end

  task automatic chk(input string t, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", t, what, got, exp);
    end
  endtask

  task automatic compare();
    chk(tag, "out", {out_data, out_chk}, m_out);
    chk("R4", "wr_en", W'(wr_en), W'(m_wr_en));
    if (m_wr_en) chk("R4", "wr_word", {wr_data, wr_chk}, m_wr);
    chk("R5/R7", "scrub_req", W'(scrub_req), W'(m_scrub));
    chk("R6", "halt_req", W'(halt_req), W'(m_scrub));
  endtask

  task automatic cyc(input logic e, input logic a);
    err_in = e; scrub_ack = a;
    raw_data = DATA_W'($urandom); raw_chk = CHK_W'($urandom);
    fix_data = DATA_W'($urandom); fix_chk = CHK_W'($urandom);
    @(posedge clk); #2;
    compare();
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic e, input logic a);
    for (int i = 0; i < n; i++) cyc(e, a);
  endtask

  task automatic do_reset();
    rst = 1'b1; err_in = 0; scrub_ack = 0;
    @(posedge clk); @(posedge clk); #2;
    tag = "R8";
    chk("R8", "out after reset", {out_data, out_chk}, '0);
    chk("R8", "wr after reset", {wr_data, wr_chk, wr_en}, '0);
    chk("R8", "req after reset", W'({scrub_req, halt_req}), '0);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired: got hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    tag = "R1"; run(20, 0, 0);
    tag = "R2"; run(3, 1, 0);
    tag = "R3"; run(4, 0, 0);
    tag = "R2"; run(2, 1, 0); run(1, 0, 0); run(3, 1, 0); // re-rise in release window
    tag = "R3"; run(3, 0, 0);
    tag = "R5"; run(5, 1, 0); run(3, 0, 0);                 // exactly at limit: no fire
    run(6, 1, 0);
    chk("R5", "fire on count 6 with limit 5", W'(scrub_req), W'(1));
    tag = "R7"; run(2, 1, 1);                                // set wins over ack
    run(4, 0, 0);                                            // held, output on shadow
    chk("R7", "request held without ack", W'(scrub_req), W'(1));
    run(1, 0, 1);
    chk("R7", "ack clears", W'(scrub_req), W'(0));
    tag = "R3"; run(4, 0, 0);
    tag = "R5"; tmo_limit = 8'd0; run(1, 1, 0);
    chk("R5", "limit zero fires at once", W'(scrub_req), W'(1));
    tag = "R7"; run(2, 0, 1);
    tag = "R1"; tmo_limit = 8'd3; run(10, 0, 0);
    do_reset();
    tag = "R1"; run(5, 0, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule